// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 interrupt inputs and steers each one to a chosen set of processor cores and parent interrupt lines. Every source has its own trigger mode: level or edge, and its own polarity. It also has an enable bit and a byte-wide route entry. The route entry picks which of four parent lines the source raises and which of four cores see it. The result is sixteen registered interrupt outputs, one per (core, line) pair.

Software reaches all state through a simple single-cycle read/write port with a 32-bit data path and byte-lane strobes. Enables are changed only through separate write-one-to-set and write-one-to-clear strobe registers, so concurrent agents never need a read-modify-write. Edge-triggered sources hold their event in a latch until software acknowledges it by writing a one to the source's bit in any per-core status word. Level-triggered sources follow the synchronized input.

Top module: `lirq_router`

## Requirements
- R1: After reset, every route byte, enable bit, polarity bit and edge-select bit reads 0, every bit of `irq_out` is 0, and `bus_rdata` is 0.
- R2: Source i owns the route byte at byte offset i (0x00 to 0x1F). The byte sits in lane i mod 4 (bits 8*(i mod 4)+7 down to 8*(i mod 4)) of the word at offset 4*(i/4). A write changes only the lanes whose `bus_be` bit is 1, and a read returns all four bytes of the word.
- R3: In a route byte, bit 4+n selects parent line n and bit c selects core c. Output `irq_out[4*c+n]` belongs to core c, line n. A byte with no line bit or no core bit drives no output.
- R4: A write to offset 0x28 sets each enable bit whose data bit is 1 and leaves the others unchanged. The enable vector reads back at 0x24, and reads of 0x28 and 0x2C return 0.
- R5: A write to offset 0x2C clears each enable bit whose data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears every enable.
- R6: Polarity (0x30) and edge-select (0x34) are read/write words with bit i for source i. With edge-select 0, source i is pending while its synchronized input equals its polarity bit (1 = active-high, 0 = active-low).
- R7: With edge-select 1, a rising input edge when polarity is 1, or a falling edge when polarity is 0, latches source i as pending. The opposite edge and input return do not clear it. Writing a word to any status offset 0x40, 0x44, 0x48 or 0x4C clears the latches whose data bit is 1; zero bits have no effect.
- R8: Each input passes two synchronizer flops. A level-mode change applied between clock edges appears on `irq_out` at the third rising edge and not at the second.
- R9: `irq_out[4*c+n]` is the registered OR of all sources that are pending, enabled and routed to both core c and line n. A disabled edge source still latches, and it raises its output once enabled.
- R10: The word at 0x40+4*c reads the pending, enabled sources routed to core c. The word at 0x20 reads raw pending for all sources, enabled or not. A read returns data on `bus_rdata` after the clock edge that accepts it.
- R11: Clearing a source's edge-select bit discards its edge latch, so a later return to edge mode starts with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Raw asynchronous interrupt inputs, bit i is source i |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane strobes, honoured in the route region |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 16 | Parent line outputs, index 4*core+line |

## Verification
The bench builds the block with its default parameters: 32 sources, four lines, four cores and a two-flop synchronizer. With these values the whole register map exists, including the last route word and the status word of core 3. The vector table can therefore reach the highest output index (core 3, line 3), source 31, and route bytes that name several cores or no line at all. The same build fixes the three-edge input latency, which the bench checks at exact cycle boundaries.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;
  localparam int BUS_W   = 32;
  localparam int ROUTE_W = 8;
  localparam int LANES   = BUS_W / ROUTE_W;

  // word indices (byte offset / 4) of the control registers
  localparam int WORD_RAW  = 8;   // 0x20 raw pending
  localparam int WORD_EN   = 9;   // 0x24 enable readback
  localparam int WORD_SET  = 10;  // 0x28 enable set strobe
  localparam int WORD_CLR  = 11;  // 0x2C enable clear strobe
  localparam int WORD_POL  = 12;  // 0x30 polarity
  localparam int WORD_EDGE = 13;  // 0x34 edge select
  localparam int WORD_STAT = 16;  // 0x40 first per-core status word
endpackage

// File: rtl/lirq_sync.sv
`timescale 1ns/1ps
module lirq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lirq_detect.sv
`timescale 1ns/1ps
module lirq_detect #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] sync_in,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] edge_sel,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_in;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic rise, fall, hit, level_act;
    assign rise      = sync_in[i] & ~prev_q[i];
    assign fall      = ~sync_in[i] & prev_q[i];
    assign hit       = pol[i] ? rise : fall;
    assign level_act = ~(sync_in[i] ^ pol[i]);

    always_ff @(posedge clk) begin
      if (rst) latch_q[i] <= 1'b0;
      else     latch_q[i] <= edge_sel[i] & ((latch_q[i] & ~clr[i]) | hit);
    end

    assign pend[i] = edge_sel[i] ? latch_q[i] : level_act;
  end
endmodule

// File: rtl/lirq_regfile.sv
`timescale 1ns/1ps
module lirq_regfile
  import lirq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int AW    = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sel,
  input  logic                              wr,
  input  logic [AW-1:0]                     addr,
  input  logic [BUS_W-1:0]                  wdata,
  input  logic [LANES-1:0]                  be,
  input  logic [NSRC-1:0]                   raw_pend,
  input  logic [NCORE-1:0][NSRC-1:0]        core_stat,
  output logic [NSRC-1:0]                   en_q,
  output logic [NSRC-1:0]                   pol_q,
  output logic [NSRC-1:0]                   edge_q,
  output logic [NSRC-1:0][ROUTE_W-1:0]      route_q,
  output logic [NSRC-1:0]                   clr_o,
  output logic [BUS_W-1:0]                  rdata_q
);
  localparam int WA_W   = AW - 2;
  localparam int RWORDS = NSRC / LANES;

  logic [WA_W-1:0]  wa;
  logic             wr_en, rd_en, stat_hit;
  logic [BUS_W-1:0] rd_nx;
  logic [1:0]       unused_lo;

  assign wa        = addr[AW-1:2];
  assign unused_lo = addr[1:0];
  assign wr_en     = sel & wr;
  assign rd_en     = sel & ~wr;
  assign stat_hit  = (int'(wa) >= WORD_STAT) && (int'(wa) < WORD_STAT + NCORE);

  // route bytes: byte-lane writes
  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < RWORDS; w++)
        for (int l = 0; l < LANES; l++)
          if (int'(wa) == w && be[l])
            route_q[w*LANES+l] <= wdata[l*ROUTE_W +: ROUTE_W];
    end
  end

  // control words
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else if (wr_en) begin
      if (int'(wa) == WORD_SET)  en_q   <= en_q | wdata[NSRC-1:0];
      if (int'(wa) == WORD_CLR)  en_q   <= en_q & ~wdata[NSRC-1:0];
      if (int'(wa) == WORD_POL)  pol_q  <= wdata[NSRC-1:0];
      if (int'(wa) == WORD_EDGE) edge_q <= wdata[NSRC-1:0];
    end
  end

  // edge acknowledge strobe, applied at the accepting edge
  assign clr_o = (wr_en && stat_hit) ? wdata[NSRC-1:0] : '0;

  // read mux
  always_comb begin
    rd_nx = '0;
    for (int w = 0; w < RWORDS; w++)
      if (int'(wa) == w)
        for (int l = 0; l < LANES; l++)
          rd_nx[l*ROUTE_W +: ROUTE_W] = route_q[w*LANES+l];
    if (int'(wa) == WORD_RAW)  rd_nx[NSRC-1:0] = raw_pend;
    if (int'(wa) == WORD_EN)   rd_nx[NSRC-1:0] = en_q;
    if (int'(wa) == WORD_POL)  rd_nx[NSRC-1:0] = pol_q;
    if (int'(wa) == WORD_EDGE) rd_nx[NSRC-1:0] = edge_q;
    for (int c = 0; c < NCORE; c++)
      if (int'(wa) == WORD_STAT + c) rd_nx[NSRC-1:0] = core_stat[c];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nx;
  end
endmodule

// File: rtl/lirq_fanout.sv
`timescale 1ns/1ps
module lirq_fanout
  import lirq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NLINE = 4,
  parameter int NCORE = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NSRC-1:0]               pend,
  input  logic [NSRC-1:0]               en,
  input  logic [NSRC-1:0][ROUTE_W-1:0]  route,
  output logic [NCORE-1:0][NSRC-1:0]    core_stat,
  output logic [NCORE*NLINE-1:0]        irq_q
);
  localparam int LINE_LSB = NCORE;

  logic [NSRC-1:0]              live;
  logic [NCORE-1:0][NSRC-1:0]   core_hit;
  logic [NLINE-1:0][NSRC-1:0]   line_hit;

  assign live = pend & en;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      assign core_hit[c][i] = route[i][c];
    end
    for (genvar n = 0; n < NLINE; n++) begin : g_line
      assign line_hit[n][i] = route[i][LINE_LSB+n];
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_out_core
    assign core_stat[c] = live & core_hit[c];
    for (genvar n = 0; n < NLINE; n++) begin : g_out_line
      always_ff @(posedge clk) begin
        if (rst) irq_q[c*NLINE+n] <= 1'b0;
        else     irq_q[c*NLINE+n] <= |(live & core_hit[c] & line_hit[n]);
      end
    end
  end
endmodule

// File: rtl/lirq_router.sv
`timescale 1ns/1ps
module lirq_router
  import lirq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NLINE  = 4,
  parameter int NCORE  = 4,
  parameter int AW     = 8,
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         irq_in,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  input  logic [LANES-1:0]        bus_be,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic [NCORE*NLINE-1:0]  irq_out
);
  logic [NSRC-1:0]              sync_w, pend_w, en_q, pol_q, edge_q, clr_w;
  logic [NSRC-1:0][ROUTE_W-1:0] route_q;
  logic [NCORE-1:0][NSRC-1:0]   core_stat;

  lirq_sync #(.W(NSRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(sync_w)
  );

  lirq_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst(rst), .sync_in(sync_w), .pol(pol_q),
    .edge_sel(edge_q), .clr(clr_w), .pend(pend_w)
  );

  lirq_regfile #(.NSRC(NSRC), .NCORE(NCORE), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .raw_pend(pend_w), .core_stat(core_stat),
    .en_q(en_q), .pol_q(pol_q), .edge_q(edge_q), .route_q(route_q),
    .clr_o(clr_w), .rdata_q(bus_rdata)
  );

  lirq_fanout #(.NSRC(NSRC), .NLINE(NLINE), .NCORE(NCORE)) u_fan (
    .clk(clk), .rst(rst), .pend(pend_w), .en(en_q), .route(route_q),
    .core_stat(core_stat), .irq_q(irq_out)
  );
endmodule

// File: rtl/lirq_router_chk.sv
`timescale 1ns/1ps
module lirq_router_chk #(
  parameter int NSRC = 32,
  parameter int NOUT = 16,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [NOUT-1:0] irq_out,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] edge_sel,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] clr
);
  logic set_wr, clr_wr, strobe_rd;
  assign set_wr    = bus_sel && bus_wr && (bus_addr == AW'('h28));
  assign clr_wr    = bus_sel && bus_wr && (bus_addr == AW'('h2C));
  assign strobe_rd = bus_sel && !bus_wr &&
                     ((bus_addr == AW'('h28)) || (bus_addr == AW'('h2C)));

  // R5: an all-ones clear strobe leaves nothing enabled
  a_r5_disable_all: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && bus_wdata[NSRC-1:0] == '1) |=> (en == '0));

  // R4: set strobe turns on every written one
  a_r4_set_bits: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((en & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  // R4: set strobe never clears an enabled source
  a_r4_keep_bits: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((en & $past(en)) == $past(en)));

  // R4: strobe registers read as zero
  a_r4_strobe_reads_zero: assert property (@(posedge clk) disable iff (rst)
    strobe_rd |=> (bus_rdata == '0));

  // R9: no output can be raised without some enabled source one cycle earlier
  a_r9_out_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (|irq_out) |-> $past(|en));

  // R7: an edge latch only drops after an acknowledge or a mode change
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (($past(clr) == '0) && $stable(edge_sel)) |->
      ((($past(pend) & ~pend) & edge_sel) == '0));
endmodule

bind lirq_router lirq_router_chk #(.NSRC(NSRC), .NOUT(NCORE*NLINE), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .en(en_q), .edge_sel(edge_q), .pend(pend_w), .clr(clr_w)
);

// File: tb/lirq_router_tb.sv
`timescale 1ns/1ps
module lirq_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lirq_router u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {src[4:0], route[7:0], pol, expected irq_out[15:0]}
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {5'd0,  8'h11, 1'b1, 16'h0001},
    {5'd5,  8'h24, 1'b0, 16'h0200},
    {5'd31, 8'h88, 1'b1, 16'h8000},
    {5'd10, 8'h43, 1'b1, 16'h0044},
    {5'd17, 8'h30, 1'b1, 16'h0000},
    {5'd22, 8'h0F, 1'b1, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = b;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic route_write(input int src, input logic [7:0] val);
    bus_write(8'((src / 4) * 4), 32'(val) << (8 * (src % 4)), 4'(1 << (src % 4)));
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle(3);

    // R1: reset state
    check("R1 irq_out", 32'(irq_out), 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read(8'h24, rd); check("R1 enable", rd, 32'h0);
    bus_read(8'h30, rd); check("R1 polarity", rd, 32'h0);
    bus_read(8'h34, rd); check("R1 edge", rd, 32'h0);
    bus_read(8'h00, rd); check("R1 route word0", rd, 32'h0);
    bus_read(8'h1C, rd); check("R1 route word7", rd, 32'h0);

    // R10: raw pending shows every active-low idle source
    bus_read(8'h20, rd); check("R10 raw pending", rd, 32'hFFFF_FFFF);

    // R2: byte lanes of route storage
    route_write(4, 8'h3C);
    route_write(5, 8'hA5);
    bus_read(8'h04, rd); check("R2 lanes", rd, 32'h0000_A53C);
    bus_write(8'h04, 32'hFFFF_FFFF, 4'b0100);
    bus_read(8'h04, rd); check("R2 strobe", rd, 32'h00FF_A53C);
    bus_write(8'h04, 32'h0, 4'hF);

    // R4 / R5: strobe enables
    bus_write(8'h28, 32'h0000_00F0, 4'hF);
    bus_write(8'h28, 32'h0000_000F, 4'hF);
    bus_read(8'h24, rd); check("R4 set", rd, 32'h0000_00FF);
    bus_read(8'h28, rd); check("R4 set reads 0", rd, 32'h0);
    bus_read(8'h2C, rd); check("R4 clr reads 0", rd, 32'h0);
    bus_write(8'h2C, 32'h0000_0030, 4'hF);
    bus_read(8'h24, rd); check("R5 clear", rd, 32'h0000_00CF);
    bus_write(8'h2C, 32'hFFFF_FFFF, 4'hF);

    // R6: polarity and edge registers
    bus_write(8'h30, 32'h1234_5678, 4'hF);
    bus_read(8'h30, rd); check("R6 polarity rw", rd, 32'h1234_5678);
    bus_write(8'h34, 32'h0F0F_0000, 4'hF);
    bus_read(8'h34, rd); check("R6 edge rw", rd, 32'h0F0F_0000);
    bus_write(8'h30, 32'h0, 4'hF);
    bus_write(8'h34, 32'h0, 4'hF);

    // R3 / R6 / R9: level routing vectors
    for (int v = 0; v < NV; v++) begin
      int src;
      logic pol;
      src = int'(VEC[v][29:25]);
      pol = VEC[v][16];
      bus_write(8'h30, 32'(pol) << src, 4'hF);
      irq_in[src] = pol;
      route_write(src, VEC[v][24:17]);
      bus_write(8'h28, 32'h1 << src, 4'hF);
      settle(5);
      check($sformatf("R3/R6 vector %0d", v), 32'(irq_out), 32'(VEC[v][15:0]));
      bus_write(8'h2C, 32'hFFFF_FFFF, 4'hF);
      route_write(src, 8'h00);
      bus_write(8'h30, 32'h0, 4'hF);
      irq_in[src] = 1'b0;
      settle(3);
      check($sformatf("R9 vector %0d masked", v), 32'(irq_out), 32'h0);
    end

    // R5 / R9: everything enabled, then mass disable
    route_write(0, 8'h11);
    bus_write(8'h28, 32'hFFFF_FFFF, 4'hF);
    settle(3);
    check("R9 all enabled", 32'(irq_out), 32'h0001);
    bus_write(8'h2C, 32'hFFFF_FFFF, 4'hF);
    bus_read(8'h24, rd); check("R5 mass disable", rd, 32'h0);
    settle(2);
    check("R5 outputs off", 32'(irq_out), 32'h0);

    // R8: latency through synchronizer and output register
    bus_write(8'h30, 32'h1, 4'hF);
    bus_write(8'h28, 32'h1, 4'hF);
    settle(3);
    check("R8 idle", 32'(irq_out), 32'h0);
    irq_in[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 not at second edge", 32'(irq_out), 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 at third edge", 32'(irq_out), 32'h0001);
    bus_write(8'h2C, 32'hFFFF_FFFF, 4'hF);
    route_write(0, 8'h00);
    bus_write(8'h30, 32'h0, 4'hF);
    irq_in[0] = 1'b0;

    // R7: edge latching on source 3, line 0 core 1 -> bit 4
    bus_write(8'h30, 32'h8, 4'hF);
    bus_write(8'h34, 32'h8, 4'hF);
    route_write(3, 8'h12);
    bus_write(8'h28, 32'h8, 4'hF);
    settle(4);
    check("R7 no edge yet", 32'(irq_out), 32'h0);
    irq_in[3] = 1'b1;
    settle(5);
    check("R7 rising latched", 32'(irq_out), 32'h0010);
    irq_in[3] = 1'b0;
    settle(5);
    check("R7 held after input drop", 32'(irq_out), 32'h0010);
    bus_read(8'h44, rd); check("R10 core1 status", rd, 32'h8);
    bus_read(8'h40, rd); check("R10 core0 status", rd, 32'h0);
    bus_write(8'h40, 32'hFFFF_FFF7, 4'hF);
    settle(3);
    check("R7 zero bit no clear", 32'(irq_out), 32'h0010);
    bus_write(8'h4C, 32'h8, 4'hF);
    settle(3);
    check("R7 acknowledged", 32'(irq_out), 32'h0);

    // R7: falling edge with polarity 0
    bus_write(8'h30, 32'h0, 4'hF);
    irq_in[3] = 1'b1;
    settle(5);
    check("R7 rise ignored at pol 0", 32'(irq_out), 32'h0);
    irq_in[3] = 1'b0;
    settle(5);
    check("R7 falling latched", 32'(irq_out), 32'h0010);

    // R11: leaving edge mode drops the latch
    irq_in[3] = 1'b1;
    settle(5);
    check("R11 latched before switch", 32'(irq_out), 32'h0010);
    bus_write(8'h34, 32'h0, 4'hF);
    settle(3);
    check("R11 level inactive", 32'(irq_out), 32'h0);
    bus_write(8'h34, 32'h8, 4'hF);
    settle(4);
    check("R11 latch discarded", 32'(irq_out), 32'h0);

    // R9: masked edge source still latches
    bus_write(8'h2C, 32'h8, 4'hF);
    irq_in[3] = 1'b0;
    settle(5);
    check("R9 masked no output", 32'(irq_out), 32'h0);
    bus_read(8'h20, rd); check("R10 raw includes masked", rd, 32'hFFFF_FFFF);
    bus_read(8'h44, rd); check("R10 status masked", rd, 32'h0);
    bus_write(8'h28, 32'h8, 4'hF);
    settle(3);
    check("R9 latched shows on enable", 32'(irq_out), 32'h0010);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule